// File: doc/BRIEF.md
# Interval Timer and Interrupt Collector

This block gives a word-oriented processor a program-loadable elapsed-time counter and a simple interrupt front end. A 20-bit down-counter is loaded by a strobe. It steps down once per timer tick. The tick comes from the system clock through a parameterised prescaler. When the count reaches zero, the counter raises the timer interrupt source.

Four external service lines are latched into pending bits next to the timer source. Source 1 is I/O completion and sources 2 to 4 are peripheral requests. Each source has an enable flag that the program sets and clears. A single master inhibit, set on reset and cleared by an enable instruction strobe, gates every source.

When an enabled source is pending and the inhibit is clear, the block raises a vector request toward the core. The request carries a save word that the core stores at word 0 before it fetches from word 1. The save word holds the interrupted program counter and a one-hot cause field. Taking the interrupt sets the master inhibit again, so nothing further is taken until software re-enables.

Top module: `itic_top`

## Requirements
- R1: After reset, the count is 0, all pending bits and enable flags are 0, the master inhibit is 1 and `vec_req` is 0.
- R2: A cycle with `tmr_load` high makes `tmr_count` equal `tmr_value` on the next cycle. A load takes precedence over a tick in that cycle.
- R3: Without a load, the count drops by exactly one on each tick. A tick is one system clock in every PRESCALE, counted from reset. A count of zero stays zero and never wraps.
- R4: Pending bit 0 (timer) is set when a tick moves the count from 1 to 0. Loading the value 0 raises no timer request.
- R5: Each `ext_req[k]` line that is high in a cycle sets pending bit k+1. A pending bit stays set until the vector for that source is acknowledged.
- R6: The enable flags follow `mask_set` and `mask_clr` (bit i is source i). When both are high for a bit, the clear wins. A pending source whose flag is 0 is never taken and stays pending.
- R7: `irq_disable` sets the master inhibit and `irq_enable` clears it, with disable winning when both are high. Taking an interrupt sets the inhibit, and while it is set no new vector is raised.
- R8: If no vector is outstanding, the inhibit is 0 and some source is both pending and enabled, then `vec_req` rises on the next cycle. The lowest-numbered such source is taken.
- R9: `save_word` bits 15:0 hold `pc_now` from the taking cycle. Bit 27+i is set for cause source i, and all other bits are 0. `save_addr` is 0 and `fetch_addr` is 1.
- R10: `vec_req` and `save_word` hold steady until `vec_ack`. The cycle after an acknowledge, `vec_req` is 0 and the taken source's pending bit is clear, unless its line is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_load | input | 1 | Load strobe for the counter |
| tmr_value | input | 20 | Value loaded by the strobe |
| ext_req | input | 4 | Service lines for sources 1..4 |
| mask_set | input | 5 | Per-source enable set strobes |
| mask_clr | input | 5 | Per-source enable clear strobes |
| irq_enable | input | 1 | Clears the master inhibit |
| irq_disable | input | 1 | Sets the master inhibit |
| pc_now | input | 16 | Current program counter |
| vec_ack | input | 1 | Core acknowledges the vector |
| vec_req | output | 1 | Vector request to the core |
| save_word | output | 32 | Word for the core to store: PC plus one-hot cause |
| save_addr | output | 16 | Memory word that receives the save word |
| fetch_addr | output | 16 | Memory word fetched after the save |
| tmr_count | output | 20 | Current counter value |
| irq_pending | output | 5 | Latched pending bits, bit 0 = timer |
| irq_inhibited | output | 1 | Master inhibit state |

## Verification
The assertions assume that `vec_ack` is meaningful only while `vec_req` is high. They also assume that `tmr_value` and `pc_now` are settled values at each clock edge. The random stimulus raises `vec_ack` only when the bench sees an outstanding vector, and drives every input at the falling edge. Load values are kept small, so the counter often reaches zero. This exercises both the timer-expiry path and the load-over-tick case in a short run.

// File: rtl/itic_pkg.sv
package itic_pkg;
    localparam int CNT_W     = 20;
    localparam int PC_W      = 16;
    localparam int WORD_W    = 32;
    localparam int N_EXT     = 4;
    localparam int N_SRC     = N_EXT + 1;
    localparam int CAUSE_LSB = WORD_W - N_SRC;
    localparam int GAP_W     = CAUSE_LSB - PC_W;
    localparam logic [PC_W-1:0] SAVE_ADDR  = '0;
    localparam logic [PC_W-1:0] FETCH_ADDR = PC_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    typedef struct packed {
        logic [N_SRC-1:0]  pend;
        logic [N_SRC-1:0]  en;
        logic [N_SRC-1:0]  sel;
        logic [WORD_W-1:0] word;
        logic              inhib;
        logic              vec;
    } arb_state_t;
endpackage

// File: rtl/itic_prescaler.sv
module itic_prescaler #(
    parameter int PRESCALE = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PS_W-1:0] phase;
    } ps_state_t;

    ps_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == LAST) st_d.phase = '0;
        else                    st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = (st_q.phase == LAST);

    // R3: the tick is one cycle wide
    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/itic_countdown.sv
module itic_countdown
    import itic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    cnt_state_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.cnt = value;
        end else if (tick && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            expire   = (st_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(value));
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !load) |=> count == '0);
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && count != '0) |=> count == $past(count) - 1'b1);
    a_r4_expire_zero: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count == '0);
endmodule

// File: rtl/itic_arbiter.sv
module itic_arbiter
    import itic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  raw_req,
    input  logic [N_SRC-1:0]  en_set,
    input  logic [N_SRC-1:0]  en_clr,
    input  logic              ena,
    input  logic              dis,
    input  logic [PC_W-1:0]   pc,
    input  logic              ack,
    output logic              vec,
    output logic [WORD_W-1:0] word,
    output logic [N_SRC-1:0]  pending,
    output logic              inhibited
);
    arb_state_t       st_q, st_d;
    logic [N_SRC-1:0] elig;
    logic [N_SRC-1:0] win;
    logic             take;

    always_comb begin
        st_d = st_q;
        elig = st_q.pend & st_q.en;
        win  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && win == '0) win[i] = 1'b1;
        end
        take = !st_q.vec && !st_q.inhib && (elig != '0);

        st_d.en = (st_q.en | en_set) & ~en_clr;

        if (st_q.vec && ack) begin
            st_d.pend = st_q.pend & ~st_q.sel;
            st_d.vec  = 1'b0;
            st_d.sel  = '0;
            st_d.word = '0;
        end
        st_d.pend = st_d.pend | raw_req;

        if (take) begin
            st_d.vec   = 1'b1;
            st_d.sel   = win;
            st_d.word  = {win, {GAP_W{1'b0}}, pc};
            st_d.inhib = 1'b1;
        end else if (dis) begin
            st_d.inhib = 1'b1;
        end else if (ena) begin
            st_d.inhib = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.inhib <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec       = st_q.vec;
    assign word      = st_q.word;
    assign pending   = st_q.pend;
    assign inhibited = st_q.inhib;

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vec && !ack) |=> vec && $stable(word));
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (vec && ack) |=> !vec);
    a_r7_take_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec) |-> inhibited);
    a_r9_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
        vec |-> $countones(word[WORD_W-1:CAUSE_LSB]) == 1);
    a_r6_cause_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec) |-> ((word[WORD_W-1:CAUSE_LSB] & $past(st_q.en)) != '0));
    a_r5_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!(vec && ack)) |=> (($past(pending) & ~pending) == '0));
endmodule

// File: rtl/itic_top.sv
module itic_top
    import itic_pkg::*;
#(
    parameter int PRESCALE = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_load,
    input  logic [CNT_W-1:0]  tmr_value,
    input  logic [N_EXT-1:0]  ext_req,
    input  logic [N_SRC-1:0]  mask_set,
    input  logic [N_SRC-1:0]  mask_clr,
    input  logic              irq_enable,
    input  logic              irq_disable,
    input  logic [PC_W-1:0]   pc_now,
    input  logic              vec_ack,
    output logic              vec_req,
    output logic [WORD_W-1:0] save_word,
    output logic [PC_W-1:0]   save_addr,
    output logic [PC_W-1:0]   fetch_addr,
    output logic [CNT_W-1:0]  tmr_count,
    output logic [N_SRC-1:0]  irq_pending,
    output logic              irq_inhibited
);
    logic tick;
    logic expire;

    itic_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    itic_countdown u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (tmr_load),
        .value (tmr_value),
        .count (tmr_count),
        .expire(expire)
    );

    itic_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_req  ({ext_req, expire}),
        .en_set   (mask_set),
        .en_clr   (mask_clr),
        .ena      (irq_enable),
        .dis      (irq_disable),
        .pc       (pc_now),
        .ack      (vec_ack),
        .vec      (vec_req),
        .word     (save_word),
        .pending  (irq_pending),
        .inhibited(irq_inhibited)
    );

    assign save_addr  = SAVE_ADDR;
    assign fetch_addr = FETCH_ADDR;
endmodule

// File: tb/tb_itic_top.sv
`timescale 1ns/1ps
module tb_itic_top;
    import itic_pkg::*;
    localparam int PS = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_value;
    logic [N_EXT-1:0]  ext_req;
    logic [N_SRC-1:0]  mask_set, mask_clr;
    logic              irq_enable, irq_disable;
    logic [PC_W-1:0]   pc_now;
    logic              vec_ack;
    logic              vec_req;
    logic [WORD_W-1:0] save_word;
    logic [PC_W-1:0]   save_addr, fetch_addr;
    logic [CNT_W-1:0]  tmr_count;
    logic [N_SRC-1:0]  irq_pending;
    logic              irq_inhibited;

    itic_top #(.PRESCALE(PS)) dut (
        .clk(clk), .rst_n(rst_n), .tmr_load(tmr_load), .tmr_value(tmr_value),
        .ext_req(ext_req), .mask_set(mask_set), .mask_clr(mask_clr),
        .irq_enable(irq_enable), .irq_disable(irq_disable), .pc_now(pc_now),
        .vec_ack(vec_ack), .vec_req(vec_req), .save_word(save_word),
        .save_addr(save_addr), .fetch_addr(fetch_addr), .tmr_count(tmr_count),
        .irq_pending(irq_pending), .irq_inhibited(irq_inhibited)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state derived from the requirements
    int                m_pre;
    logic [CNT_W-1:0]  m_cnt;
    logic [N_SRC-1:0]  m_pend, m_en, m_sel;
    logic              m_inh, m_vec;
    logic [WORD_W-1:0] m_word;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N_SRC-1:0] lowest(input logic [N_SRC-1:0] v);
        for (int i = 0; i < N_SRC; i++) if (v[i]) return N_SRC'(1) << i;
        return '0;
    endfunction

    function automatic logic [WORD_W-1:0] mk_word(input logic [N_SRC-1:0] c, input logic [PC_W-1:0] p);
        return {c, {GAP_W{1'b0}}, p};
    endfunction

    task automatic idle_inputs();
        tmr_load = 0; tmr_value = '0; ext_req = '0; mask_set = '0; mask_clr = '0;
        irq_enable = 0; irq_disable = 0; vec_ack = 0;
    endtask

    task automatic model_reset();
        m_pre = 0; m_cnt = '0; m_pend = '0; m_en = '0; m_sel = '0;
        m_inh = 1; m_vec = 0; m_word = '0;
    endtask

    task automatic model_step();
        logic tk, exp_z, tk_take;
        logic [N_SRC-1:0] elig, np;
        tk    = (m_pre == PS - 1);
        exp_z = tk && m_cnt == CNT_W'(1) && !tmr_load;
        elig  = m_pend & m_en;
        tk_take = !m_vec && !m_inh && elig != '0;
        np = m_pend;
        if (m_vec && vec_ack) np = np & ~m_sel;
        np = np | {ext_req, exp_z};
        if (tk_take) begin
            m_inh = 1;
        end else if (irq_disable) m_inh = 1;
        else if (irq_enable) m_inh = 0;
        if (m_vec && vec_ack) begin m_vec = 0; m_sel = '0; m_word = '0; end
        if (tk_take) begin
            m_vec = 1; m_sel = lowest(elig); m_word = mk_word(lowest(elig), pc_now);
        end
        m_pend = np;
        m_en   = (m_en | mask_set) & ~mask_clr;
        if (tmr_load) m_cnt = tmr_value;
        else if (tk && m_cnt != '0) m_cnt = m_cnt - 1'b1;
        m_pre = tk ? 0 : m_pre + 1;
    endtask

    // one clock: model update, edge, compare at the falling edge
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R3 count", 32'(tmr_count), 32'(m_cnt));
        chk("R5 pending", 32'(irq_pending), 32'(m_pend));
        chk("R7 inhibit", 32'(irq_inhibited), 32'(m_inh));
        chk("R8 vec_req", 32'(vec_req), 32'(m_vec));
        if (m_vec) chk("R9 save_word", save_word, m_word);
        idle_inputs();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        pc_now = 16'h0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1 count", 32'(tmr_count), 0);
        chk("R1 pending", 32'(irq_pending), 0);
        chk("R1 inhibit", 32'(irq_inhibited), 1);
        chk("R1 vec_req", 32'(vec_req), 0);
        chk("R9 save_addr", 32'(save_addr), 0);
        chk("R9 fetch_addr", 32'(fetch_addr), 1);

        // R2 load, R3 countdown without wrap, R4 expiry
        tmr_load = 1; tmr_value = 20'd3;
        cycle();
        chk("R2 loaded", 32'(tmr_count), 3);
        for (int k = 0; k < 20; k++) if (tmr_count != 0) cycle();
        chk("R4 timer pending", 32'(irq_pending[0]), 1);
        repeat (8) cycle();
        chk("R3 stays zero", 32'(tmr_count), 0);

        // R6/R7: enabled but inhibited, nothing taken
        mask_set = 5'h1F;
        cycle();
        repeat (3) cycle();
        chk("R7 inhibited blocks", 32'(vec_req), 0);

        // R5: latch sources 1 and 3
        ext_req = 4'b0101;
        cycle();
        chk("R5 latched", 32'(irq_pending), 32'b01011);
        pc_now = 16'h1234;
        irq_enable = 1;
        cycle();
        chk("R7 enable clears", 32'(irq_inhibited), 0);
        cycle();
        chk("R8 vec raised", 32'(vec_req), 1);
        chk("R8 lowest wins", 32'(save_word), mk_word(5'b00001, 16'h1234));
        chk("R7 take sets inhibit", 32'(irq_inhibited), 1);
        pc_now = 16'hBEEF;
        repeat (3) cycle();
        chk("R10 held", save_word, 32'h0800_1234);
        vec_ack = 1;
        cycle();
        chk("R10 released", 32'(vec_req), 0);
        chk("R10 pending cleared", 32'(irq_pending), 32'b01010);
        repeat (3) cycle();
        chk("R7 no retake", 32'(vec_req), 0);

        // R6: mask source 1, source 3 taken instead
        mask_clr = 5'b00010;
        cycle();
        pc_now = 16'h00AA;
        irq_enable = 1;
        cycle();
        cycle();
        chk("R6 masked skipped", save_word, 32'h4000_00AA);
        vec_ack = 1;
        cycle();
        chk("R6 masked stays pending", 32'(irq_pending), 32'b00010);

        // R4: loading zero raises nothing
        tmr_load = 1; tmr_value = '0;
        cycle();
        repeat (10) cycle();
        chk("R4 zero load silent", 32'(irq_pending[0]), 0);

        // R6 clear wins, R7 enable
        mask_set = 5'b10000; mask_clr = 5'b10000; ext_req = 4'b1000; irq_enable = 1;
        cycle();
        repeat (4) cycle();
        chk("R6 clear wins", 32'(vec_req), 0);
        chk("R6 pending kept", 32'(irq_pending), 32'b10010);
        irq_enable = 1; irq_disable = 1;
        cycle();
        chk("R7 disable wins", 32'(irq_inhibited), 1);

        // random phase
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            tmr_load    = ($urandom_range(0, 15) == 0);
            tmr_value   = CNT_W'($urandom_range(0, 12));
            ext_req     = ($urandom_range(0, 7) == 0) ? N_EXT'($urandom) : '0;
            mask_set    = ($urandom_range(0, 5) == 0) ? N_SRC'($urandom) : '0;
            mask_clr    = ($urandom_range(0, 7) == 0) ? N_SRC'($urandom) : '0;
            irq_enable  = ($urandom_range(0, 3) == 0);
            irq_disable = ($urandom_range(0, 11) == 0);
            pc_now      = PC_W'($urandom);
            vec_ack     = vec_req && ($urandom_range(0, 2) == 0);
            cycle();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule